// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Match Alarm

This block keeps wall-clock time inside a chip. Seconds, minutes and hours are stored as packed BCD bytes, and a day count is stored as a plain 15-bit binary number. The count advances once for each pulse on a one-second enable input. Software reaches all state through a byte-wide register port: an 8-bit address, write data, a write strobe, and combinational read data for the address currently presented.

An alarm holds a minute, an hour and a day value. Each of the three fields has its own participation enable. When the seconds roll over to 00 and every participating field equals the running time, a sticky flag is raised. The interrupt output is that flag gated by an interrupt enable. The flag is cleared by writing a one to it.

A small run controller sequences the counter. Its states are ST_OFF (counting disabled), ST_IDLE (enabled, waiting for a tick) and ST_UPDATE (the one cycle in which a tick is applied, reported as busy). These are its transitions:
- ST_OFF goes to ST_IDLE once the run enable is set.
- ST_IDLE and ST_UPDATE go to ST_OFF when the run enable is clear.
- ST_IDLE and ST_UPDATE go to ST_UPDATE on a tick.
- ST_IDLE and ST_UPDATE go to ST_IDLE otherwise.

Top module: `bcd_time_keeper`

## Requirements
- R1: After reset every register reads 0x00, the alarm interrupt output is 0, and the controller is in ST_OFF.
- R2: The control register is at address 0x14. Its bits are: bit 0 run enable, bit 1 interrupt enable, bit 2 alarm flag, bit 3 minute-match enable, bit 4 hour-match enable, bit 5 day-match enable, bit 7 busy (read-only). Bit 6 reads 0. While bit 0 is 0, ticks are ignored and the time holds. A tick that arrives in ST_OFF is ignored even in the cycle the enable is written.
- R3: Seconds at 0x15 count 00..59 in BCD. A ones digit of 9 wraps to 0 and increments the tens digit. Rolling from 59 to 00 advances minutes at 0x16 in the same update.
- R4: Minutes rolling from 59 to 00 advance hours at 0x17. Hours rolling from 23 to 00 increment the binary day count, whose low byte is at 0x18 and high byte at 0x19. The carry crosses from the low byte into the high byte.
- R5: The day count is 15 bits wide. Bit 7 written to 0x19 is dropped and reads 0. An increment from 0x7FFF gives 0x0000.
- R6: A tick sampled while the block is in ST_IDLE or ST_UPDATE with the run enable set places the block in ST_UPDATE for the next cycle. During that cycle bit 7 of 0x14 reads 1. The advanced time is readable from the cycle after it.
- R7: A write to any of 0x15..0x19 during the busy cycle stores the written byte, and the increment of that tick is dropped entirely.
- R8: The alarm minute (BCD) is at 0x1A, the alarm hour (BCD) at 0x1B, and the alarm day at 0x1C (low byte) and 0x1D (high byte, bits 6:0). In the cycle after seconds roll to 00, the flag (bit 2) is set if at least one match enable is set and every enabled field equals the current time. The flag stays set until it is cleared.
- R9: A field whose match enable is 0 takes no part in the comparison. With all three match enables at 0, the flag never sets.
- R10: Writing 0x14 with bit 2 = 1 clears the flag. Writing bit 2 = 0 leaves the flag unchanged. A new match in the same cycle as a clear leaves the flag set.
- R11: The alarm interrupt output is high exactly when the flag and the interrupt enable (bit 1) are both 1.
- R12: Addresses other than 0x14..0x1D read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The tests drive the following patterns:
- Single ticks from mid-minute values, which separate the BCD digit carry from the seconds rollover.
- Ticks from 23:59:59, with days 0x00FF and 0x7FFF, which expose the full carry chain, the carry across the day bytes and the 15-bit wrap.
- A time write placed exactly in the busy cycle, which shows whether the write wins and the tick is dropped rather than merged.
- Alarm runs with all fields enabled, with the hour only, and with none, which tell apart correct per-field masking, stickiness and the write-one-to-clear rule from a flag that tracks the comparison directly.

// File: rtl/bcdk_pkg.sv
package bcdk_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_UPDATE = 2'd2
    } run_state_t;

    localparam logic [7:0] A_CTRL  = 8'h14;
    localparam logic [7:0] A_SEC   = 8'h15;
    localparam logic [7:0] A_MIN   = 8'h16;
    localparam logic [7:0] A_HOUR  = 8'h17;
    localparam logic [7:0] A_DAYL  = 8'h18;
    localparam logic [7:0] A_DAYH  = 8'h19;
    localparam logic [7:0] A_AMIN  = 8'h1A;
    localparam logic [7:0] A_AHOUR = 8'h1B;
    localparam logic [7:0] A_ADAYL = 8'h1C;
    localparam logic [7:0] A_ADAYH = 8'h1D;

    localparam int B_RUN  = 0;
    localparam int B_IEN  = 1;
    localparam int B_FLAG = 2;
    localparam int B_MEN  = 3;
    localparam int B_HEN  = 4;
    localparam int B_DEN  = 5;
    localparam int B_BUSY = 7;

    function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] limit);
        return (v[3:0] <= 4'd9) && (v <= limit);
    endfunction

endpackage

// File: rtl/bcd_pair_ctr.sv
module bcd_pair_ctr #(
    parameter logic [7:0] LIMIT = 8'h59
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] value,
    output logic       carry
);
    logic [7:0] q;
    logic       at_limit;

    assign at_limit = (q == LIMIT);
    assign carry    = step && at_limit;
    assign value    = q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 8'h00;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            if (at_limit)
                q <= 8'h00;
            else if (q[3:0] >= 4'd9)
                q <= {q[7:4] + 4'd1, 4'd0};
            else
                q <= q + 8'd1;
        end
    end
endmodule

// File: rtl/day_ctr.sv
module day_ctr #(
    parameter int W = 15,
    localparam int HW = W - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load_lo,
    input  logic          load_hi,
    input  logic [7:0]    lo_val,
    input  logic [HW-1:0] hi_val,
    output logic [W-1:0]  value
);
    logic [W-1:0] q;

    assign value = q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_lo || load_hi) begin
            if (load_lo) q[7:0]   <= lo_val;
            if (load_hi) q[W-1:8] <= hi_val;
        end else if (step) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
    parameter int W = 15
) (
    input  logic         check,
    input  logic         en_min,
    input  logic         en_hour,
    input  logic         en_day,
    input  logic [7:0]   cur_min,
    input  logic [7:0]   cur_hour,
    input  logic [W-1:0] cur_day,
    input  logic [7:0]   al_min,
    input  logic [7:0]   al_hour,
    input  logic [W-1:0] al_day,
    output logic         hit
);
    logic any_en;
    logic min_ok;
    logic hour_ok;
    logic day_ok;

    always_comb begin
        any_en  = en_min || en_hour || en_day;
        min_ok  = !en_min  || (cur_min  == al_min);
        hour_ok = !en_hour || (cur_hour == al_hour);
        day_ok  = !en_day  || (cur_day  == al_day);
        hit     = check && any_en && min_ok && hour_ok && day_ok;
    end
endmodule

// File: rtl/bcd_time_keeper.sv
module bcd_time_keeper #(
    parameter int DAY_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    output logic [7:0] reg_rdata,
    output logic       alarm_irq
);
    import bcdk_pkg::*;

    localparam int HW = DAY_W - 8;

    run_state_t state_q, state_d;

    logic             cal_en, aien, en_min, en_hour, en_day;
    logic             alarm_flag;
    logic             roll_pend;
    logic [7:0]       al_min, al_hour;
    logic [DAY_W-1:0] al_day;

    logic [7:0]       sec_val, min_val, hour_val;
    logic [DAY_W-1:0] day_q;
    logic             sec_carry, min_carry, hour_carry;

    logic             busy;
    logic             wr_ctrl, time_wr, step;
    logic             hit;

    // write decode
    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign time_wr = reg_we && (reg_addr >= A_SEC) && (reg_addr <= A_DAYH);
    assign step    = busy && cal_en && !time_wr;

    // run controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // run controller: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cal_en) state_d = ST_IDLE;
            end
            ST_IDLE, ST_UPDATE: begin
                if (!cal_en)   state_d = ST_OFF;
                else if (tick) state_d = ST_UPDATE;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // run controller: outputs
    always_comb begin
        busy = 1'b0;
        unique case (state_q)
            ST_UPDATE: busy = 1'b1;
            ST_OFF, ST_IDLE: busy = 1'b0;
            default: busy = 1'b0;
        endcase
    end

    // counter cascade
    bcd_pair_ctr #(.LIMIT(8'h59)) u_sec (
        .clk(clk), .rst_n(rst_n), .step(step),
        .load(reg_we && reg_addr == A_SEC), .load_val(reg_wdata),
        .value(sec_val), .carry(sec_carry)
    );

    bcd_pair_ctr #(.LIMIT(8'h59)) u_min (
        .clk(clk), .rst_n(rst_n), .step(sec_carry),
        .load(reg_we && reg_addr == A_MIN), .load_val(reg_wdata),
        .value(min_val), .carry(min_carry)
    );

    bcd_pair_ctr #(.LIMIT(8'h23)) u_hour (
        .clk(clk), .rst_n(rst_n), .step(min_carry),
        .load(reg_we && reg_addr == A_HOUR), .load_val(reg_wdata),
        .value(hour_val), .carry(hour_carry)
    );

    day_ctr #(.W(DAY_W)) u_day (
        .clk(clk), .rst_n(rst_n), .step(hour_carry),
        .load_lo(reg_we && reg_addr == A_DAYL),
        .load_hi(reg_we && reg_addr == A_DAYH),
        .lo_val(reg_wdata), .hi_val(reg_wdata[HW-1:0]),
        .value(day_q)
    );

    // alarm compare, one cycle after seconds roll to 00
    alarm_cmp #(.W(DAY_W)) u_cmp (
        .check(roll_pend), .en_min(en_min), .en_hour(en_hour), .en_day(en_day),
        .cur_min(min_val), .cur_hour(hour_val), .cur_day(day_q),
        .al_min(al_min), .al_hour(al_hour), .al_day(al_day),
        .hit(hit)
    );

    // control bits, alarm fields, flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_en     <= 1'b0;
            aien       <= 1'b0;
            en_min     <= 1'b0;
            en_hour    <= 1'b0;
            en_day     <= 1'b0;
            alarm_flag <= 1'b0;
            roll_pend  <= 1'b0;
            al_min     <= 8'h00;
            al_hour    <= 8'h00;
            al_day     <= '0;
        end else begin
            roll_pend <= sec_carry;
            if (hit)
                alarm_flag <= 1'b1;
            else if (wr_ctrl && reg_wdata[B_FLAG])
                alarm_flag <= 1'b0;
            if (wr_ctrl) begin
                cal_en  <= reg_wdata[B_RUN];
                aien    <= reg_wdata[B_IEN];
                en_min  <= reg_wdata[B_MEN];
                en_hour <= reg_wdata[B_HEN];
                en_day  <= reg_wdata[B_DEN];
            end
            if (reg_we && reg_addr == A_AMIN)  al_min  <= reg_wdata;
            if (reg_we && reg_addr == A_AHOUR) al_hour <= reg_wdata;
            if (reg_we && reg_addr == A_ADAYL) al_day[7:0] <= reg_wdata;
            if (reg_we && reg_addr == A_ADAYH) al_day[DAY_W-1:8] <= reg_wdata[HW-1:0];
        end
    end

    // read mux
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {busy, 1'b0, en_day, en_hour, en_min, alarm_flag, aien, cal_en};
            A_SEC:   reg_rdata = sec_val;
            A_MIN:   reg_rdata = min_val;
            A_HOUR:  reg_rdata = hour_val;
            A_DAYL:  reg_rdata = day_q[7:0];
            A_DAYH:  reg_rdata = {{(8-HW){1'b0}}, day_q[DAY_W-1:8]};
            A_AMIN:  reg_rdata = al_min;
            A_AHOUR: reg_rdata = al_hour;
            A_ADAYL: reg_rdata = al_day[7:0];
            A_ADAYH: reg_rdata = {{(8-HW){1'b0}}, al_day[DAY_W-1:8]};
            default: reg_rdata = 8'h00;
        endcase
    end

    assign alarm_irq = alarm_flag && aien;

endmodule

// File: rtl/bcdk_checker.sv
module bcdk_checker #(
    parameter int DAY_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [7:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             reg_we,
    input logic             alarm_irq,
    input logic             busy,
    input logic             cal_en,
    input logic             alarm_flag,
    input logic             roll_pend,
    input logic [7:0]       sec_val,
    input logic [DAY_W-1:0] day_q
);
    import bcdk_pkg::*;

    // R2: no advance while the run enable is clear
    a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_en && !reg_we) |=> $stable(sec_val));

    // R3: a valid seconds value stays valid unless software writes it
    a_r3_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd_ok(sec_val, 8'h59) && !(reg_we && reg_addr == A_SEC)) |=> bcd_ok(sec_val, 8'h59));

    // R4: the day count only holds or steps by one unless written
    a_r4_day_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (reg_addr == A_DAYL || reg_addr == A_DAYH))
        |=> (day_q == $past(day_q)) || (day_q == $past(day_q) + 1'b1));

    // R6: busy lasts one cycle unless another tick follows
    a_r6_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> !busy);

    // R7: a seconds write always lands
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_SEC) |=> (sec_val == $past(reg_wdata)));

    // R8: the flag rises only right after a seconds rollover
    a_r8_flag_after_roll: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(roll_pend));

    // R10: the flag is sticky until a write-one clear
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !(reg_we && reg_addr == A_CTRL && reg_wdata[B_FLAG])) |=> alarm_flag);

    // R11: no interrupt without a pending flag
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_flag);

endmodule

bind bcd_time_keeper bcdk_checker #(.DAY_W(DAY_W)) u_bcdk_checker (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .alarm_irq(alarm_irq), .busy(busy), .cal_en(cal_en),
    .alarm_flag(alarm_flag), .roll_pend(roll_pend),
    .sec_val(sec_val), .day_q(day_q)
);

// File: tb/bcd_time_keeper_bench.sv
module bcd_time_keeper_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       alarm_irq;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    bcd_time_keeper u_bcd_time_keeper (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_st;              // 0 off, 1 idle, 2 update
    int m_s, m_m, m_h, m_d;
    int m_amin, m_ahour, m_aday;
    bit m_run, m_ien, m_men, m_hen, m_den, m_flag, m_roll;

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        logic [7:0] r;
        r[7:4] = 4'((v / 10) % 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    function automatic logic [7:0] mread(input logic [7:0] a);
        case (a)
            8'h14: return {m_st == 2, 1'b0, m_den, m_hen, m_men, m_flag, m_ien, m_run};
            8'h15: return i2b(m_s);
            8'h16: return i2b(m_m);
            8'h17: return i2b(m_h);
            8'h18: return 8'(m_d % 256);
            8'h19: return 8'(m_d / 256);
            8'h1A: return 8'(m_amin);
            8'h1B: return 8'(m_ahour);
            8'h1C: return 8'(m_aday % 256);
            8'h1D: return 8'(m_aday / 256);
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_s = 0; m_m = 0; m_h = 0; m_d = 0;
            m_amin = 0; m_ahour = 0; m_aday = 0;
            m_run = 0; m_ien = 0; m_men = 0; m_hen = 0; m_den = 0;
            m_flag = 0; m_roll = 0;
        end else begin
            bit twr, match, nroll;
            int nst;
            twr = reg_we && reg_addr >= 8'h15 && reg_addr <= 8'h19;
            match = m_roll && (m_men || m_hen || m_den)
                    && (!m_men || i2b(m_m) == 8'(m_amin))
                    && (!m_hen || i2b(m_h) == 8'(m_ahour))
                    && (!m_den || m_d == m_aday);
            if (!m_run) nst = 0;
            else if (m_st == 0) nst = 1;
            else if (tick) nst = 2;
            else nst = 1;
            nroll = 0;
            if (m_st == 2 && m_run && !twr) begin
                m_s++;
                if (m_s == 60) begin
                    m_s = 0; nroll = 1; m_m++;
                    if (m_m == 60) begin
                        m_m = 0; m_h++;
                        if (m_h == 24) begin
                            m_h = 0; m_d = (m_d + 1) % 32768;
                        end
                    end
                end
            end
            m_roll = nroll;
            if (match) m_flag = 1;
            else if (reg_we && reg_addr == 8'h14 && reg_wdata[2]) m_flag = 0;
            if (reg_we) begin
                case (reg_addr)
                    8'h14: begin
                        m_run = reg_wdata[0]; m_ien = reg_wdata[1];
                        m_men = reg_wdata[3]; m_hen = reg_wdata[4]; m_den = reg_wdata[5];
                    end
                    8'h15: m_s = b2i(reg_wdata);
                    8'h16: m_m = b2i(reg_wdata);
                    8'h17: m_h = b2i(reg_wdata);
                    8'h18: m_d = (m_d / 256) * 256 + int'(reg_wdata);
                    8'h19: m_d = (m_d % 256) + int'(reg_wdata[6:0]) * 256;
                    8'h1A: m_amin = int'(reg_wdata);
                    8'h1B: m_ahour = int'(reg_wdata);
                    8'h1C: m_aday = (m_aday / 256) * 256 + int'(reg_wdata);
                    8'h1D: m_aday = (m_aday % 256) + int'(reg_wdata[6:0]) * 256;
                    default: ;
                endcase
            end
            m_st = nst;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (reg_rdata !== mread(reg_addr)) begin
                failures++;
                $display("FAIL %s rdata@%02h actual=%02h expected=%02h", cur_req, reg_addr, reg_rdata, mread(reg_addr));
            end
            checks++;
            if (alarm_irq !== (m_flag && m_ien)) begin
                failures++;
                $display("FAIL %s alarm_irq actual=%0b expected=%0b", cur_req, alarm_irq, m_flag && m_ien);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(posedge clk); #1; reg_addr = a;
        @(negedge clk);
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s direct@%02h actual=%02h expected=%02h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input logic [7:0] dl, input logic [7:0] dh);
        wr(8'h15, s); wr(8'h16, m); wr(8'h17, h); wr(8'h18, dl); wr(8'h19, dh);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        for (int a = 8'h14; a <= 8'h1D; a++) expect_rd(8'(a), 8'h00, "R1");

        // R2: ticks ignored while stopped; tick with enable write ignored
        cur_req = "R2";
        wr(8'h15, 8'h07);
        do_tick(3);
        expect_rd(8'h15, 8'h07, "R2");
        @(posedge clk); #1; reg_we = 1'b1; reg_addr = 8'h14; reg_wdata = 8'h01; tick = 1'b1;
        @(posedge clk); #1; reg_we = 1'b0; tick = 1'b0;
        repeat (3) @(posedge clk);
        expect_rd(8'h15, 8'h07, "R2");
        expect_rd(8'h14, 8'h01, "R2");

        // R3: BCD digit carry and minute rollover
        cur_req = "R3";
        set_time(8'h04, 8'h12, 8'h08, 8'h00, 8'h00);
        do_tick(2);
        expect_rd(8'h15, 8'h10, "R3");
        wr(8'h15, 8'h58);
        do_tick(2);
        expect_rd(8'h15, 8'h00, "R3");
        expect_rd(8'h16, 8'h13, "R3");

        // R4: full cascade with day byte carry
        cur_req = "R4";
        set_time(8'h23, 8'h59, 8'h59, 8'hFF, 8'h00);
        do_tick(1);
        expect_rd(8'h17, 8'h00, "R4");
        expect_rd(8'h18, 8'h00, "R4");
        expect_rd(8'h19, 8'h01, "R4");

        // R5: 15-bit day width and wrap
        cur_req = "R5";
        set_time(8'h23, 8'h59, 8'h59, 8'hFF, 8'hFF);
        expect_rd(8'h19, 8'h7F, "R5");
        do_tick(1);
        expect_rd(8'h18, 8'h00, "R5");
        expect_rd(8'h19, 8'h00, "R5");

        // R6: busy visible in the update cycle only
        cur_req = "R6";
        @(posedge clk); #1; reg_addr = 8'h14; tick = 1'b1;
        @(posedge clk); #1; tick = 1'b0;
        @(negedge clk);
        checks++;
        if (reg_rdata[7] !== 1'b1) begin
            failures++;
            $display("FAIL R6 busy actual=%0b expected=1", reg_rdata[7]);
        end
        @(negedge clk);
        checks++;
        if (reg_rdata[7] !== 1'b0) begin
            failures++;
            $display("FAIL R6 busy actual=%0b expected=0", reg_rdata[7]);
        end

        // R7: write in the busy cycle wins and drops the tick
        cur_req = "R7";
        set_time(8'h05, 8'h20, 8'h59, 8'h03, 8'h00);
        @(posedge clk); #1; tick = 1'b1;
        @(posedge clk); #1; tick = 1'b0; reg_we = 1'b1; reg_addr = 8'h16; reg_wdata = 8'h40;
        @(posedge clk); #1; reg_we = 1'b0;
        expect_rd(8'h15, 8'h59, "R7");
        expect_rd(8'h16, 8'h40, "R7");

        // R8: full match, flag sticky
        cur_req = "R8";
        set_time(8'h10, 8'h29, 8'h58, 8'h05, 8'h00);
        wr(8'h1A, 8'h30); wr(8'h1B, 8'h10); wr(8'h1C, 8'h05); wr(8'h1D, 8'h00);
        wr(8'h14, 8'h3B);
        do_tick(1);
        expect_rd(8'h14, 8'h3B, "R8");
        do_tick(1);
        expect_rd(8'h14, 8'h3F, "R8");
        do_tick(2);
        expect_rd(8'h14, 8'h3F, "R8");

        // R10: write 0 keeps, write 1 clears
        cur_req = "R10";
        wr(8'h14, 8'h3B);
        expect_rd(8'h14, 8'h3F, "R10");
        wr(8'h14, 8'h3F);
        expect_rd(8'h14, 8'h3B, "R10");

        // R9: hour-only match, then no enables
        cur_req = "R9";
        set_time(8'h10, 8'h45, 8'h59, 8'h09, 8'h00);
        wr(8'h14, 8'h13);
        do_tick(1);
        expect_rd(8'h14, 8'h17, "R9");
        wr(8'h14, 8'h07);
        wr(8'h15, 8'h59);
        do_tick(1);
        expect_rd(8'h14, 8'h03, "R9");

        // R11: interrupt follows flag and enable
        cur_req = "R11";
        wr(8'h14, 8'h11);
        wr(8'h15, 8'h59);
        do_tick(1);
        expect_rd(8'h14, 8'h15, "R11");
        wr(8'h14, 8'h13);
        @(negedge clk);
        checks++;
        if (alarm_irq !== 1'b1) begin
            failures++;
            $display("FAIL R11 alarm_irq actual=%0b expected=1", alarm_irq);
        end

        // R12: unmapped addresses
        cur_req = "R12";
        wr(8'h20, 8'hFF);
        wr(8'h13, 8'hAA);
        expect_rd(8'h20, 8'h00, "R12");
        expect_rd(8'h13, 8'h00, "R12");
        expect_rd(8'h14, 8'h17, "R12");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule